// File: doc/BRIEF.md
# Vector Load/Store Address Generator

This block turns one scalar load or store description into a stream of effective addresses, one per vector element. At start it captures a full-width base value, a short signed displacement, an optional offset value, the access size in bytes, an addressing-mode code and an element count. It then walks an element index from zero upward and emits one address per cycle on a valid/ready output.

Two of the modes derive a stride from fields the scalar instruction already has. In unit-strided mode the stride is the access size. In element-strided mode the stride is the displacement. In indexed mode the address is a base plus an offset, and exactly one of the two is a vector operand. That operand is read element by element through a combinational register-file read port. Indexed offsets may be narrowed by an element-width override, with a choice of signed or unsigned extension. The base is never narrowed.

Top module: `vec_agen`

## Requirements
- R1: After reset `addr_valid`, `done` and `busy` are all 0.
- R2: With `mode` = 0 (unit-strided), element i has address `base + op_bytes*i`, modulo 2^64.
- R3: With `mode` = 1 (element-strided), element i has address `base + sext(imm)*i`, modulo 2^64. The displacement `imm` is sign-extended from IMM_W bits.
- R4: With `mode[1]` = 1 (indexed) and `vec_base` = 0, element i has address `base + X(rf_data)`, where `rf_data` is the read-port value for `rf_idx` = i and X is the offset extension of R6.
- R5: With `mode[1]` = 1 and `vec_base` = 1, element i has address `rf_data + X(offs)`. The vector base `rf_data` is always used at its full 64 bits.
- R6: In indexed mode with `ew_ovr` = 1, the offset keeps only its low 8, 16, 32 or 64 bits for `ew_sel` = 0, 1, 2 or 3. It is then sign-extended when `off_signed` = 1 and zero-extended when `off_signed` = 0. With `ew_ovr` = 0, or in a strided mode, the override and sign fields have no effect on the address.
- R7: A run of count n delivers exactly n addresses, for elements 0 to n-1 in increasing order.
- R8: While `addr_valid` is high and `addr_ready` is low, `addr_valid` stays high and `addr` holds its value. With `addr_ready` held high, once the run has started, one address is delivered every cycle.
- R9: `done` is a one-cycle pulse in the cycle after the last address is accepted. `busy` is low in that cycle.
- R10: A start with count 0 produces no address and raises `done` in the next cycle.
- R11: A `start` pulse while `busy` is high is ignored. The run in progress continues with its captured settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; honoured only when not busy |
| count | input | CNT_W | Number of elements |
| mode | input | 2 | 0 unit-strided, 1 element-strided, 2 or 3 indexed |
| base | input | ADDR_W | Scalar base value |
| imm | input | IMM_W | Signed displacement |
| offs | input | ADDR_W | Scalar offset value (indexed, vector base) |
| op_bytes | input | OPW_W | Access size in bytes |
| ew_ovr | input | 1 | Enable offset width override |
| ew_sel | input | 2 | Override width: 8, 16, 32, 64 bits |
| off_signed | input | 1 | 1 sign-extends, 0 zero-extends the narrowed offset |
| vec_base | input | 1 | Indexed: 1 base is the vector operand, 0 offset is |
| rf_idx | output | CNT_W | Element index for the vector operand read |
| rf_data | input | ADDR_W | Vector operand element for `rf_idx`, same cycle |
| busy | output | 1 | A run is in progress |
| addr_valid | output | 1 | Address output valid |
| addr_ready | input | 1 | Consumer accepts the address |
| addr | output | ADDR_W | Effective address |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The assertions assume three things about the inputs. The read port returns the element for the index currently shown on `rf_idx` within the same cycle. `addr_ready` may toggle freely. `start` is a pulse that the design may ignore. The bench models the register file as a combinational function of `rf_idx` and a per-run seed, so the vector data always matches the index. It drives `addr_ready` randomly, with long all-ready stretches to test throughput. It raises `start` again during one run, and the pins it changes at that moment must not leak into the addresses.

// File: rtl/vec_agen_pkg.sv
package vec_agen_pkg;
  localparam int NUM_EW = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic       idx_mode;
    logic       elem_mode;
    logic       vec_base;
    logic       ew_ovr;
    logic [1:0] ew_sel;
    logic       off_signed;
  } agen_cfg_t;
endpackage

// File: rtl/vec_agen_seq.sv
module vec_agen_seq
  import vec_agen_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic             adv,
  input  logic             fire,
  input  logic             out_last,
  output logic             accept,
  output logic             issue,
  output logic             issue_last,
  output logic [CNT_W-1:0] idx,
  output logic             busy,
  output logic             done
);
  seq_state_t       state;
  logic [CNT_W-1:0] cnt_l;

  assign accept     = start && (state == ST_IDLE);
  assign issue      = (state == ST_RUN) && adv;
  assign issue_last = issue && (idx == cnt_l - CNT_W'(1));
  assign busy       = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      idx   <= '0;
      cnt_l <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            cnt_l <= count;
            idx   <= '0;
            if (count == '0) done  <= 1'b1;
            else             state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (issue) begin
            idx <= idx + CNT_W'(1);
            if (issue_last) state <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (fire && out_last) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r7_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> (idx < cnt_l));
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_idle_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  a_r10_empty_run: assert property (@(posedge clk) disable iff (rst)
    (accept && count == '0) |=> (done && !busy));
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (cnt_l == $past(cnt_l)));
endmodule

// File: rtl/vec_agen_stride.sv
module vec_agen_stride #(
  parameter int W     = 64,
  parameter int IMM_W = 16,
  parameter int OPW_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             elem_mode,
  input  logic [IMM_W-1:0] imm,
  input  logic [OPW_W-1:0] op_bytes,
  input  logic             step_en,
  output logic [W-1:0]     ofs
);
  logic [W-1:0] step;
  logic [W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= '0;
      acc  <= '0;
    end else if (load) begin
      step <= elem_mode ? {{(W-IMM_W){imm[IMM_W-1]}}, imm}
                        : {{(W-OPW_W){1'b0}}, op_bytes};
      acc  <= '0;
    end else if (step_en) begin
      acc <= acc + step;
    end
  end

  assign ofs = acc;
endmodule

// File: rtl/vec_agen_ext.sv
module vec_agen_ext
  import vec_agen_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] val,
  input  logic         ovr,
  input  logic [1:0]   sel,
  input  logic         sgn,
  output logic [W-1:0] res
);
  logic [W-1:0] narrow [NUM_EW];

  for (genvar k = 0; k < NUM_EW; k++) begin : g_ew
    localparam int EW = 8 << k;
    if (EW < W) begin : g_cut
      assign narrow[k] = {{(W-EW){sgn & val[EW-1]}}, val[EW-1:0]};
    end else begin : g_full
      assign narrow[k] = val;
    end
  end

  assign res = ovr ? narrow[sel] : val;
endmodule

// File: rtl/vec_agen.sv
module vec_agen
  import vec_agen_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CNT_W  = 8,
  parameter int IMM_W  = 16,
  parameter int OPW_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  count,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  input  logic [ADDR_W-1:0] offs,
  input  logic [OPW_W-1:0]  op_bytes,
  input  logic              ew_ovr,
  input  logic [1:0]        ew_sel,
  input  logic              off_signed,
  input  logic              vec_base,
  output logic [CNT_W-1:0]  rf_idx,
  input  logic [ADDR_W-1:0] rf_data,
  output logic              busy,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);
  agen_cfg_t         cfg_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] offs_q;
  logic              last_q;
  logic              accept, issue, issue_last, adv, fire;
  logic [CNT_W-1:0]  idx;
  logic [ADDR_W-1:0] stride_ofs;
  logic [ADDR_W-1:0] idx_ofs_raw, idx_ofs, sum_base, addr_next;

  assign adv  = !addr_valid || addr_ready;
  assign fire = addr_valid && addr_ready;

  vec_agen_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .count(count),
    .adv(adv), .fire(fire), .out_last(last_q),
    .accept(accept), .issue(issue), .issue_last(issue_last),
    .idx(idx), .busy(busy), .done(done)
  );

  vec_agen_stride #(.W(ADDR_W), .IMM_W(IMM_W), .OPW_W(OPW_W)) u_stride (
    .clk(clk), .rst(rst), .load(accept), .elem_mode(mode[0]),
    .imm(imm), .op_bytes(op_bytes), .step_en(issue), .ofs(stride_ofs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      base_q <= '0;
      offs_q <= '0;
    end else if (accept) begin
      cfg_q.idx_mode   <= mode[1];
      cfg_q.elem_mode  <= mode[0];
      cfg_q.vec_base   <= vec_base;
      cfg_q.ew_ovr     <= ew_ovr;
      cfg_q.ew_sel     <= ew_sel;
      cfg_q.off_signed <= off_signed;
      base_q           <= base;
      offs_q           <= offs;
    end
  end

  assign rf_idx      = idx;
  assign idx_ofs_raw = cfg_q.vec_base ? offs_q : rf_data;
  assign sum_base    = (cfg_q.idx_mode && cfg_q.vec_base) ? rf_data : base_q;

  vec_agen_ext #(.W(ADDR_W)) u_ext (
    .val(idx_ofs_raw), .ovr(cfg_q.ew_ovr), .sel(cfg_q.ew_sel),
    .sgn(cfg_q.off_signed), .res(idx_ofs)
  );

  assign addr_next = sum_base + (cfg_q.idx_mode ? idx_ofs : stride_ofs);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_valid <= 1'b0;
      addr       <= '0;
      last_q     <= 1'b0;
    end else if (issue) begin
      addr_valid <= 1'b1;
      addr       <= addr_next;
      last_q     <= issue_last;
    end else if (addr_ready) begin
      addr_valid <= 1'b0;
    end
  end

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr)));
  a_r8_no_bubble: assert property (@(posedge clk) disable iff (rst)
    (fire && !last_q && busy) |=> addr_valid);
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (rst)
    (fire && last_q) |=> done);
  a_r10_no_output_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !addr_valid) |=> !addr_valid);
endmodule

// File: tb/vec_agen_test.sv
module vec_agen_test;
  localparam int AW = 64;
  localparam int CW = 8;
  localparam int IW = 16;
  localparam int OW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [CW-1:0] count;
  logic [1:0]    mode;
  logic [AW-1:0] base, offs;
  logic [IW-1:0] imm;
  logic [OW-1:0] op_bytes;
  logic          ew_ovr, off_signed, vec_base;
  logic [1:0]    ew_sel;
  logic [CW-1:0] rf_idx;
  logic [AW-1:0] rf_data;
  logic          busy, addr_valid, addr_ready, done;
  logic [AW-1:0] addr;
  logic [AW-1:0] vseed;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  vec_agen uut (
    .clk(clk), .rst(rst), .start(start), .count(count), .mode(mode),
    .base(base), .imm(imm), .offs(offs), .op_bytes(op_bytes),
    .ew_ovr(ew_ovr), .ew_sel(ew_sel), .off_signed(off_signed),
    .vec_base(vec_base), .rf_idx(rf_idx), .rf_data(rf_data),
    .busy(busy), .addr_valid(addr_valid), .addr_ready(addr_ready),
    .addr(addr), .done(done)
  );

  function automatic logic [AW-1:0] vec_val(logic [AW-1:0] sd, logic [CW-1:0] i);
    logic [AW-1:0] x;
    x = {56'd0, i};
    return (sd * 64'h9E3779B97F4A7C15) ^ (x * 64'hD1B54A32D192ED03) ^ (x << 61);
  endfunction

  assign rf_data = vec_val(vseed, rf_idx);

  logic [CW-1:0] e_cnt;
  logic [1:0]    e_mode;
  logic [AW-1:0] e_base, e_offs, e_seed;
  logic [IW-1:0] e_imm;
  logic [OW-1:0] e_op;
  logic          e_ovr, e_sgn, e_vb;
  logic [1:0]    e_sel;

  function automatic logic [AW-1:0] ext_ofs(logic [AW-1:0] v);
    logic [AW-1:0] m;
    if (!e_ovr || e_sel == 2'd3) return v;
    m = (64'd1 << (8 << e_sel)) - 64'd1;
    if (e_sgn && v[(8 << e_sel) - 1]) return v | ~m;
    return v & m;
  endfunction

  function automatic logic [AW-1:0] exp_addr(int i);
    logic [AW-1:0] ii;
    ii = AW'(i);
    if (e_mode[1]) begin
      if (e_vb) return vec_val(e_seed, CW'(i)) + ext_ofs(e_offs);
      return e_base + ext_ofs(vec_val(e_seed, CW'(i)));
    end
    if (e_mode[0]) return e_base + {{(AW-IW){e_imm[IW-1]}}, e_imm} * ii;
    return e_base + {{(AW-OW){1'b0}}, e_op} * ii;
  endfunction

  function automatic string tag_of();
    if (e_mode[1]) return e_vb ? "R5" : (e_ovr ? "R6" : "R4");
    return e_mode[0] ? "R3" : "R2";
  endfunction

  task automatic chk(bit ok, string tg, logic [AW-1:0] act, logic [AW-1:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tg, act, expv);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  // rmode 0: ready always high, 1: random ready, 2: random ready plus restart attempt
  task automatic run_case(int n, logic [1:0] md, logic [AW-1:0] b, logic [IW-1:0] im,
                          logic [AW-1:0] of, logic [OW-1:0] op, logic ov, logic [1:0] sl,
                          logic sg, logic vb, int rmode);
    int  k;
    bit  stall_prev, last_prev, saw_done, started;
    logic [AW-1:0] prev_addr;
    @(negedge clk);
    vseed = {$urandom, $urandom};
    count = CW'(n); mode = md; base = b; imm = im; offs = of; op_bytes = op;
    ew_ovr = ov; ew_sel = sl; off_signed = sg; vec_base = vb; start = 1'b1;
    e_cnt = CW'(n); e_mode = md; e_base = b; e_imm = im; e_offs = of; e_op = op;
    e_ovr = ov; e_sel = sl; e_sgn = sg; e_vb = vb; e_seed = vseed;
    @(negedge clk);
    k = 0; stall_prev = 0; last_prev = 0; saw_done = 0; started = 0; prev_addr = '0;
    for (int it = 0; it < 400; it++) begin
      addr_ready = (rmode == 0) ? 1'b1 : ($urandom % 4 != 0);
      if (rmode == 2 && it == 3) begin
        start = 1'b1; count = 8'd2; mode = ~md; base = ~b; offs = ~of; imm = ~im;
      end else begin
        start = 1'b0;
      end
      #1;
      if (stall_prev)
        chk(addr_valid && addr == prev_addr, "R8", addr, prev_addr);
      if (done) begin
        chk(k == n, "R7", AW'(k), AW'(n));
        chk(last_prev && !busy, "R9", {62'd0, last_prev, busy}, 64'd2);
        saw_done = 1;
        break;
      end
      if (rmode == 0 && started && k < n)
        chk(addr_valid, "R8", {63'd0, addr_valid}, 64'd1);
      last_prev = 0;
      if (addr_valid && addr_ready) begin
        chk(addr == exp_addr(k), (rmode == 2) ? "R11" : tag_of(), addr, exp_addr(k));
        k++;
        started = 1;
        last_prev = (k == n);
      end
      stall_prev = addr_valid && !addr_ready;
      prev_addr = addr;
      @(negedge clk);
    end
    chk(saw_done, "R9", {63'd0, saw_done}, 64'd1);
    start = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=%h exp=%h", 64'd1, 64'd0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst = 1'b1; start = 1'b0; count = '0; mode = '0; base = '0; imm = '0;
    offs = '0; op_bytes = '0; ew_ovr = 0; ew_sel = '0; off_signed = 0;
    vec_base = 0; addr_ready = 1'b0; vseed = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!addr_valid && !done && !busy, "R1", {61'd0, addr_valid, done, busy}, 64'd0);

    // R2 doubleword unit stride, and wrap past 2^64
    run_case(5, 2'd0, 64'h1000, '0, '0, 4'd8, 0, 2'd0, 0, 0, 0);
    run_case(4, 2'd0, 64'hFFFF_FFFF_FFFF_FFF0, '0, '0, 4'd8, 0, 2'd0, 0, 0, 1);
    // R3 negative displacement, R6 override ignored in a strided mode
    run_case(6, 2'd1, 64'h20, 16'hFFF0, '0, 4'd4, 1, 2'd0, 1, 0, 0);
    run_case(3, 2'd1, 64'h8000, 16'h0123, '0, 4'd2, 0, 2'd0, 0, 0, 1);
    // R4 full-width offset, R6 each narrowed width and sign choice
    run_case(5, 2'd2, 64'h4000_0000, '0, '0, 4'd8, 0, 2'd0, 0, 0, 1);
    for (int s = 0; s < 4; s++) begin
      run_case(4, 2'd2, 64'h1_0000_0000, '0, '0, 4'd8, 1, 2'(s), 1, 0, 1);
      run_case(4, 2'd3, 64'h1_0000_0000, '0, '0, 4'd8, 1, 2'(s), 0, 0, 1);
    end
    // R5 vector base with narrowed negative scalar offset
    run_case(5, 2'd2, '0, '0, 64'h0000_0000_0000_80F0, 4'd8, 1, 2'd1, 1, 1, 1);
    run_case(5, 2'd2, '0, '0, 64'h0000_0000_0000_80F0, 4'd8, 1, 2'd1, 0, 1, 0);
    // R7 single element, R8 back-to-back throughput
    run_case(1, 2'd0, 64'h40, '0, '0, 4'd1, 0, 2'd0, 0, 0, 0);
    run_case(12, 2'd1, 64'h100, 16'h0010, '0, 4'd1, 0, 2'd0, 0, 0, 0);
    // R11 restart attempt during a run
    run_case(10, 2'd1, 64'h7000, 16'h0008, '0, 4'd8, 0, 2'd0, 0, 0, 2);
    run_case(10, 2'd2, 64'h9000, '0, '0, 4'd8, 1, 2'd0, 1, 0, 2);

    // R10 zero count
    @(negedge clk);
    count = '0; mode = 2'd0; start = 1'b1; addr_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(done && !addr_valid, "R10", {62'd0, done, addr_valid}, 64'd2);
    @(negedge clk);
    #1;
    chk(!done && !addr_valid && !busy, "R10", {61'd0, done, addr_valid, busy}, 64'd0);

    // random mix
    for (int r = 0; r < 40; r++) begin
      run_case(1 + int'($urandom % 20), 2'($urandom), {$urandom, $urandom},
               16'($urandom), {$urandom, $urandom}, 4'($urandom), 1'($urandom),
               2'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 2));
    end

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule